// File: doc/BRIEF.md
# Padded Line Coordinate Remapper

This block moves a layer rectangle from unpadded panel rows into a padded row space. In that space each group of M real rows is followed by D filler rows, so one full period spans N = M + D rows. The caller supplies a top row Y, a height H, the group size M and the filler count D. It pulses `start`, and `done` returns the padded top row, the number of real rows left before the first filler group, and the padded height of the whole rectangle.

The quotient and remainder come from one shared restoring divider that produces a single quotient bit per cycle. The top row and the bottom row (Y + H − 1) are divided one after the other, and the results are combined with one multiply-add per row. `busy` covers the whole computation. Results are held on the outputs until a later run finishes successfully. A zero group size is refused: it raises `err` and leaves the results untouched. Whether the ratio is valid or reduced is decided upstream. H is taken to be at least one.

Top module: `padmap_remap`

## Requirements
- R1: On a successful run, `pad_y` equals (Y mod M) + (Y div M) × (M + D).
- R2: With L = Y + H − 1, the padded bottom row is (L div M) × (M + D) + (L mod M), and `pad_h` equals that row minus `pad_y`, plus one.
- R3: On a successful run, `lead_lines` equals M − (Y mod M), which is never zero.
- R4: If M is zero when a start is accepted, `done` pulses with `err` high and `pad_y`, `lead_lines` and `pad_h` keep their previous values. `err` stays high until the next accepted start, and a successful run ends with `err` low.
- R5: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start with nonzero M until the last compute cycle, and it is low while `done` is high.
- R6: A `start` while `busy` is high is ignored. The running computation finishes with the inputs captured at its own start.
- R7: The three result outputs change only in the cycle where `done` is high.
- R8: After synchronous reset, `busy`, `done` and `err` are low and all result outputs are zero.
- R9: A `start` in the same cycle as `done` is accepted, and a new computation begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation when idle |
| row_y | input | 16 | Top row Y in unpadded space |
| height | input | 16 | Rectangle height H (at least 1) |
| grp_active | input | 16 | Real rows per group, M |
| grp_dummy | input | 16 | Filler rows per group, D |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last accepted start had M equal to zero |
| pad_y | output | 34 | Padded top row |
| lead_lines | output | 16 | Real rows before the first filler group |
| pad_h | output | 34 | Padded height of the rectangle |

## Verification
Completion of one run and acceptance of the next can fall in the same cycle. The bench raises `start` with fresh operands in the very cycle it sees `done`. It then judges two things: the finished result is read intact, and `busy` rises with the new run giving its own correct mapping. A second overlap is a `start` pulsed partway through a run with different operands. The finished result must match the first operands only.

// File: rtl/padmap_pkg.sv
package padmap_pkg;

    localparam int ROW_W  = 16;
    localparam int SPAN_W = ROW_W + 1;
    localparam int OUT_W  = 2 * SPAN_W;

    typedef enum logic [1:0] {
        PM_IDLE,
        PM_DIV_TOP,
        PM_DIV_BOT
    } pm_state_e;

    typedef struct packed {
        logic [OUT_W-1:0] pad_y;
        logic [ROW_W-1:0] lead;
        logic [OUT_W-1:0] pad_h;
    } pm_result_t;

    // Place a row given its group index and offset within the group.
    function automatic logic [OUT_W-1:0] fold_row(
        input logic [SPAN_W-1:0] quo,
        input logic [ROW_W-1:0]  rem,
        input logic [SPAN_W-1:0] period
    );
        return OUT_W'(quo) * OUT_W'(period) + OUT_W'(rem);
    endfunction

endpackage

// File: rtl/padmap_divider.sv
module padmap_divider #(
    parameter int DVD_W = 17,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder,
    output logic             fin
);

    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVS_W-1:0] acc;
    logic [DVD_W-1:0] qr;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic             fin_q;
    logic [DVS_W:0]   shifted;
    logic [DVS_W:0]   diff;
    logic             fits;

    always_comb begin
        shifted = {acc, qr[DVD_W-1]};
        fits    = (shifted >= {1'b0, divisor});
        diff    = shifted - {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            qr    <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                acc <= '0;
                qr  <= dividend;
                cnt <= CNT_W'(DVD_W);
                run <= 1'b1;
            end else if (run) begin
                acc <= fits ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
                qr  <= {qr[DVD_W-2:0], fits};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    run   <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign quotient  = qr;
    assign remainder = acc;
    assign fin       = fin_q;

endmodule

// File: rtl/padmap_seq.sv
module padmap_seq
    import padmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_y,
    input  logic [ROW_W-1:0]  height,
    input  logic [ROW_W-1:0]  grp_active,
    input  logic [ROW_W-1:0]  grp_dummy,
    output logic              div_go,
    output logic [SPAN_W-1:0] div_dividend,
    output logic [ROW_W-1:0]  div_divisor,
    input  logic [SPAN_W-1:0] div_quo,
    input  logic [ROW_W-1:0]  div_rem,
    input  logic              div_fin,
    output logic              busy,
    output logic              done,
    output logic              err,
    output pm_result_t        result
);

    pm_state_e         state;
    logic [ROW_W-1:0]  y_q;
    logic [SPAN_W-1:0] last_q;
    logic [ROW_W-1:0]  m_q;
    logic [SPAN_W-1:0] n_q;
    logic [SPAN_W-1:0] top_quo;
    logic [ROW_W-1:0]  top_rem;
    logic              go_q;
    logic              done_q;
    logic              err_q;
    pm_result_t        res_q;
    logic [OUT_W-1:0]  top_row;
    logic [OUT_W-1:0]  bot_row;

    always_comb begin
        top_row = fold_row(top_quo, top_rem, n_q);
        bot_row = fold_row(div_quo, div_rem, n_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PM_IDLE;
            y_q     <= '0;
            last_q  <= '0;
            m_q     <= '0;
            n_q     <= '0;
            top_quo <= '0;
            top_rem <= '0;
            go_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (state)
                PM_IDLE: begin
                    if (start) begin
                        y_q    <= row_y;
                        last_q <= SPAN_W'(row_y) + SPAN_W'(height) - SPAN_W'(1);
                        m_q    <= grp_active;
                        n_q    <= SPAN_W'(grp_active) + SPAN_W'(grp_dummy);
                        err_q  <= 1'b0;
                        if (grp_active == '0) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            go_q  <= 1'b1;
                            state <= PM_DIV_TOP;
                        end
                    end
                end
                PM_DIV_TOP: begin
                    if (div_fin) begin
                        top_quo <= div_quo;
                        top_rem <= div_rem;
                        go_q    <= 1'b1;
                        state   <= PM_DIV_BOT;
                    end
                end
                PM_DIV_BOT: begin
                    if (div_fin) begin
                        res_q.pad_y <= top_row;
                        res_q.lead  <= m_q - top_rem;
                        res_q.pad_h <= bot_row - top_row + OUT_W'(1);
                        done_q      <= 1'b1;
                        state       <= PM_IDLE;
                    end
                end
                default: state <= PM_IDLE;
            endcase
        end
    end

    assign div_go       = go_q;
    assign div_dividend = (state == PM_DIV_BOT) ? last_q : SPAN_W'(y_q);
    assign div_divisor  = m_q;
    assign busy         = (state != PM_IDLE);
    assign done         = done_q;
    assign err          = err_q;
    assign result       = res_q;

endmodule

// File: rtl/padmap_remap.sv
module padmap_remap
    import padmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ROW_W-1:0] row_y,
    input  logic [ROW_W-1:0] height,
    input  logic [ROW_W-1:0] grp_active,
    input  logic [ROW_W-1:0] grp_dummy,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [OUT_W-1:0] pad_y,
    output logic [ROW_W-1:0] lead_lines,
    output logic [OUT_W-1:0] pad_h
);

    logic              div_go;
    logic [SPAN_W-1:0] div_dividend;
    logic [ROW_W-1:0]  div_divisor;
    logic [SPAN_W-1:0] div_quo;
    logic [ROW_W-1:0]  div_rem;
    logic              div_fin;
    pm_result_t        result;

    padmap_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .row_y       (row_y),
        .height      (height),
        .grp_active  (grp_active),
        .grp_dummy   (grp_dummy),
        .div_go      (div_go),
        .div_dividend(div_dividend),
        .div_divisor (div_divisor),
        .div_quo     (div_quo),
        .div_rem     (div_rem),
        .div_fin     (div_fin),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .result      (result)
    );

    padmap_divider #(
        .DVD_W(SPAN_W),
        .DVS_W(ROW_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .quotient (div_quo),
        .remainder(div_rem),
        .fin      (div_fin)
    );

    assign pad_y      = result.pad_y;
    assign lead_lines = result.lead;
    assign pad_h      = result.pad_h;

endmodule

// File: rtl/padmap_remap_chk.sv
module padmap_remap_chk
    import padmap_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [OUT_W-1:0] pad_y,
    input logic [ROW_W-1:0] lead_lines,
    input logic [OUT_W-1:0] pad_h
);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(pad_y) && $stable(pad_h) && $stable(lead_lines)));

    // R4
    zero_group_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> ($stable(pad_y) && $stable(pad_h) && $stable(lead_lines)));

    // R6
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R3
    lead_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (lead_lines != '0));

endmodule

bind padmap_remap padmap_remap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .pad_y     (pad_y),
    .lead_lines(lead_lines),
    .pad_h     (pad_h)
);

// File: tb/padmap_remap_test.sv
`timescale 1ns/1ps
module padmap_remap_test;

    localparam int NV = 8;
    // stimulus: Y, H, M, D ; expected: padded top, lead rows, padded height
    localparam int unsigned TY [NV] = '{0, 7, 100, 50, 200, 65535, 65535, 5};
    localparam int unsigned TH [NV] = '{10, 5, 1, 20, 300, 1, 65535, 3};
    localparam int unsigned TM [NV] = '{3, 4, 1, 93, 93, 2, 65535, 7};
    localparam int unsigned TD [NV] = '{2, 1, 0, 45, 45, 1, 65535, 0};
    localparam int unsigned EPY[NV] = '{0, 8, 100, 50, 290, 98302, 131070, 5};
    localparam int unsigned ELD[NV] = '{3, 1, 1, 43, 79, 1, 65535, 2};
    localparam int unsigned EPH[NV] = '{16, 6, 1, 20, 435, 1, 65535, 3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] row_y = '0;
    logic [15:0] height = '0;
    logic [15:0] grp_active = '0;
    logic [15:0] grp_dummy = '0;
    logic        busy, done, err;
    logic [33:0] pad_y, pad_h;
    logic [15:0] lead_lines;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    padmap_remap uut (
        .clk(clk), .rst(rst), .start(start),
        .row_y(row_y), .height(height), .grp_active(grp_active), .grp_dummy(grp_dummy),
        .busy(busy), .done(done), .err(err),
        .pad_y(pad_y), .lead_lines(lead_lines), .pad_h(pad_h)
    );

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ops(input int unsigned y, input int unsigned h,
                           input int unsigned m, input int unsigned d);
        row_y      = 16'(y);
        height     = 16'(h);
        grp_active = 16'(m);
        grp_dummy  = 16'(d);
    endtask

    task automatic launch(input int unsigned y, input int unsigned h,
                          input int unsigned m, input int unsigned d);
        @(negedge clk);
        set_ops(y, h, m, d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 200; k++) begin
            if (done) return;
            @(negedge clk);
        end
        nchk++;
        nfail++;
        $display("FAIL R5 timeout actual done=0 expected done=1");
    endtask

    task automatic check_result(input string tag, input int unsigned py,
                                input int unsigned ld, input int unsigned ph);
        check({tag, " R1 pad_y"}, pad_y, 34'(py));
        check({tag, " R3 lead_lines"}, 34'(lead_lines), 34'(ld));
        check({tag, " R2 pad_h"}, pad_h, 34'(ph));
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check("R8 busy", 34'(busy), 34'(0));
        check("R8 done", 34'(done), 34'(0));
        check("R8 err", 34'(err), 34'(0));
        check_result("R8", 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            launch(TY[i], TH[i], TM[i], TD[i]);
            check("R5 busy after start", 34'(busy), 34'(1));
            wait_done();
            check_result($sformatf("vec%0d", i), EPY[i], ELD[i], EPH[i]);
            check("R4 err low on success", 34'(err), 34'(0));
            @(negedge clk);
            check("R5 done single pulse", 34'(done), 34'(0));
        end

        // R7: outputs hold while idle even when inputs change
        repeat (4) @(negedge clk);
        set_ops(1234, 77, 9, 9);
        repeat (4) @(negedge clk);
        check_result("R7 hold", 5, 2, 3);

        // R4: zero group size refused, outputs kept
        launch(9, 9, 0, 3);
        wait_done();
        check("R4 err raised", 34'(err), 34'(1));
        check_result("R4 kept", 5, 2, 3);
        repeat (3) @(negedge clk);
        check("R4 err held", 34'(err), 34'(1));

        // R6: start during busy ignored
        launch(7, 5, 4, 1);
        repeat (5) @(negedge clk);
        set_ops(0, 10, 3, 2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_result("R6 first ops kept", 8, 1, 6);
        check("R4 err cleared", 34'(err), 34'(0));

        // R9: start in the done cycle
        set_ops(200, 300, 93, 45);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy on done-cycle start", 34'(busy), 34'(1));
        check("R9 done dropped", 34'(done), 34'(0));
        wait_done();
        check_result("R9 second run", 290, 79, 435);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule